// File: doc/BRIEF.md
# Variable Audio Delay Line

This block holds back a stream of audio samples by a chosen number of sample periods. Samples arrive at an audio rate, for example 44.1 kHz, far below the clock rate. Each arrival is marked by a one-cycle strobe. The samples are kept in a circular buffer inside a single-port RAM of power-of-two depth.

For every accepted sample the block makes two RAM accesses in a fixed order:

- It reads the slot that the read pointer names. That slot holds the sample from D periods earlier.
- It then writes the new sample into the slot that the write pointer names.

Both pointers are plain binary counters that wrap at the buffer depth. A multiplexer chooses which pointer drives the RAM address. The write pointer stays D slots ahead of the read pointer. When the requested delay changes, the read pointer is reloaded from the write pointer minus the new delay.

The output holds a register value that changes once per accepted sample. Until the buffer has collected enough samples to cover the delay, the output is zero, so the uninitialised RAM content never appears. A delay of zero bypasses the RAM and sends the new sample straight to the output. A strobe that arrives while a read/write pair is still in progress is dropped and raises a sticky overrun flag.

Top module: `audio_delay_line`

## Requirements
- R1: While reset is held and after it is released, `smp_out` is zero and `overrun` is low. Both pointers start at slot zero.
- R2: Number the accepted samples k = 0, 1, 2, …, and let D be the delay in force. For accepted sample k with D ≥ 1 and k ≥ D, `smp_out` takes the value of sample k−D. The update happens on the second rising edge after the edge that accepted the strobe, and the value then holds until the next accepted sample. Within a sample, the RAM read comes one cycle before the RAM write.
- R3: When `delay_len` is 0, `smp_out` takes the accepted sample itself, two edges after the strobe was accepted.
- R4: For accepted sample k with D ≥ 1 and k < D, `smp_out` is zero.
- R5: `delay_len` is sampled on the edge that accepts a strobe. A new value applies to that same sample: the output becomes sample k−Dnew, or zero if k < Dnew. Samples already stored are not lost.
- R6: The buffer depth is 2^ADDR_W. Delays up to 2^ADDR_W−1 stay correct after both pointers have wrapped any number of times.
- R7: A strobe seen in either of the two cycles after an accepted strobe is ignored. It stores no sample and does not change the sample numbering. It sets `overrun` to 1, and `overrun` stays 1 until reset.
- R8: Strobes spaced three clock cycles apart are all accepted, and `overrun` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| smp_in | input | DATA_W | Incoming sample, taken with the strobe |
| delay_len | input | ADDR_W | Delay in sample periods, 0 to 2^ADDR_W−1 |
| smp_out | output | DATA_W | Delayed sample |
| overrun | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 12, which gives a 16-slot buffer. Several hundred samples therefore wrap the pointers many times. The largest delay, 15, lands on the slot right after the write pointer, so any off-by-one in the wrap or in the reload arithmetic would show up. Random delay changes exercise reloads both while the buffer is still filling and after it is full. Directed strobes that overlap a busy sample exercise the overrun path.

// File: rtl/adl_pkg.sv
package adl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } adl_phase_e;
endpackage

// File: rtl/adl_ptr_ctr.sv
module adl_ptr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (ld)       ptr_d = ld_val;
    else if (inc) ptr_d = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (ld || inc) ptr <= ptr_d;
  end
endmodule

// File: rtl/adl_spram.sv
module adl_spram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              re,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end
endmodule

// File: rtl/adl_seq.sv
module adl_seq
  import adl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic accept,
  output logic rd_en,
  output logic wr_en,
  output logic overrun
);
  adl_phase_e phase_q, phase_d;
  logic       ovr_d;

  assign accept = stb && (phase_q == PH_IDLE);
  assign rd_en  = (phase_q == PH_READ);
  assign wr_en  = (phase_q == PH_WRITE);

  always_comb begin
    phase_d = phase_q;
    ovr_d   = overrun;
    unique case (phase_q)
      PH_IDLE:  if (stb) phase_d = PH_READ;
      PH_READ:  phase_d = PH_WRITE;
      PH_WRITE: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    if (stb && (phase_q != PH_IDLE)) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      overrun <= 1'b0;
    end else begin
      phase_q <= phase_d;
      overrun <= ovr_d;
    end
  end
endmodule

// File: rtl/audio_delay_line.sv
module audio_delay_line #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_in,
  input  logic [ADDR_W-1:0] delay_len,
  output logic [DATA_W-1:0] smp_out,
  output logic              overrun
);
  localparam logic [ADDR_W-1:0] FILL_MAX = '1;

  logic              accept, rd_en, wr_en;
  logic [DATA_W-1:0] sample_q, ram_q, out_d;
  logic [ADDR_W-1:0] delay_q, rd_ptr, wr_ptr, ram_addr, fill_q, fill_d;
  logic              reload;

  adl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (smp_stb),
    .accept  (accept),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .overrun (overrun)
  );

  // reload the read counter only when the requested lead differs
  assign reload = accept && (delay_len != delay_q);

  adl_ptr_ctr #(.ADDR_W(ADDR_W)) u_wr_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (1'b0),
    .ld_val ('0),
    .inc    (wr_en),
    .ptr    (wr_ptr)
  );

  adl_ptr_ctr #(.ADDR_W(ADDR_W)) u_rd_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (reload),
    .ld_val (wr_ptr - delay_len),
    .inc    (wr_en),
    .ptr    (rd_ptr)
  );

  assign ram_addr = wr_en ? wr_ptr : rd_ptr;

  adl_spram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .addr  (ram_addr),
    .re    (rd_en),
    .we    (wr_en),
    .wdata (sample_q),
    .rdata (ram_q)
  );

  always_comb begin
    fill_d = (fill_q == FILL_MAX) ? fill_q : fill_q + ADDR_W'(1);
    if (delay_q == '0)           out_d = sample_q;
    else if (fill_q >= delay_q)  out_d = ram_q;
    else                         out_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      delay_q  <= '0;
    end else if (accept) begin
      sample_q <= smp_in;
      delay_q  <= delay_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      smp_out <= '0;
    end else if (wr_en) begin
      fill_q  <= fill_d;
      smp_out <= out_d;
    end
  end
endmodule

// File: rtl/adl_checker.sv
module adl_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [ADDR_W-1:0] delay_q,
  input logic [DATA_W-1:0] smp_out,
  input logic              overrun
);
  // R2
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);

  // R2
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // R6
  ptr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (ADDR_W'(wr_ptr - rd_ptr) == delay_q));

  // R6
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(smp_out));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind audio_delay_line adl_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_ptr  (wr_ptr),
  .rd_ptr  (rd_ptr),
  .delay_q (delay_q),
  .smp_out (smp_out),
  .overrun (overrun)
);

// File: tb/audio_delay_line_bench.sv
module audio_delay_line_bench;
  localparam int DW    = 12;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_stb;
  logic [DW-1:0] smp_in;
  logic [AW-1:0] delay_len;
  logic [DW-1:0] smp_out;
  logic          overrun;

  int n_chk = 0;
  int n_bad = 0;
  int k_cnt = 0;
  logic [DW-1:0] hist [4096];
  logic [AW-1:0] prev_d = '0;

  always #10 clk = ~clk;

  audio_delay_line #(.DATA_W(DW), .ADDR_W(AW)) u_audio_delay_line (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .delay_len(delay_len), .smp_out(smp_out), .overrun(overrun)
  );

  function automatic logic [DW-1:0] expect_out(int k, int d);
    if (d == 0) return hist[k];
    if (k < d)  return '0;
    return hist[k - d];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Call at a negedge; returns at the negedge after the output update.
  task automatic send(logic [DW-1:0] v, logic [AW-1:0] d);
    string req;
    int k;
    k = k_cnt;
    smp_stb = 1'b1; smp_in = v; delay_len = d;
    hist[k] = v;
    k_cnt++;
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (d == 0)                req = "R3";
    else if (k < int'(d))      req = "R4";
    else if (d != prev_d)      req = "R5";
    else if (k >= DEPTH)       req = "R6";
    else                       req = "R2";
    check(req, 32'(smp_out), 32'(expect_out(k, int'(d))));
    prev_d = d;
  endtask

  initial begin
    smp_stb = 1'b0; smp_in = '0; delay_len = '0; rst_n = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", 32'(smp_out), 0);
    check("R1", 32'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(smp_out), 0);

    // fill phase with delay 5: zeros, then delayed samples
    for (int i = 0; i < 12; i++) send(DW'(i + 1), 4'd5);
    // passthrough
    for (int i = 0; i < 4; i++) send(DW'($urandom), 4'd0);
    // maximum delay across wraps
    for (int i = 0; i < 40; i++) send(DW'($urandom), 4'(DEPTH - 1));
    // random mix with random delay changes
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] d;
      d = (($urandom % 8) == 0) ? AW'($urandom) : prev_d;
      send(DW'($urandom), d);
    end
    // R8: all strobes above were three cycles apart
    check("R8", 32'(overrun), 0);

    // R7: second strobe during the read phase is dropped
    begin
      int k;
      k = k_cnt;
      smp_stb = 1'b1; smp_in = 12'hABC; delay_len = 4'd0;
      hist[k] = 12'hABC; k_cnt++;
      @(negedge clk); smp_in = 12'h123;
      @(negedge clk); smp_stb = 1'b0;
      @(negedge clk);
      check("R7", 32'(smp_out), 32'h0ABC);
      check("R7", 32'(overrun), 1);
      prev_d = 4'd0;
    end
    // dropped sample must not be stored: delay 1 returns 0xABC
    send(12'h456, 4'd1);
    check("R7", 32'(smp_out), 32'h0ABC);
    for (int i = 0; i < 6; i++) send(DW'($urandom), 4'd3);
    check("R7", 32'(overrun), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule